// File: doc/BRIEF.md
# Thermometer Function-Command Controller

This block is the command layer of a single-wire temperature-sensing slave. It takes over once the address layer above it has selected the device. It holds a nine-byte scratchpad and a pair of alarm-limit bytes kept in a nonvolatile bank. The nonvolatile bank is modelled as registers with a programmable commit delay. The block decodes five function codes: start a conversion, write the two limits, stream the scratchpad out, copy the limits into the nonvolatile bank, and recall them from it.

Bits come in and go out one at a time over two bit streams with valid/ready handshakes. On the receive stream (`rx_*`) the master supplies bits and the block raises `rx_ready` only while it can accept a bit. A bit is taken on a clock where `rx_valid` and `rx_ready` are both high. On the transmit stream (`tx_*`) each read slot raises `tx_ready`. The block holds `tx_data` steady while `tx_valid` is high until that bit is consumed. The bus side may stall either stream for any number of cycles.

`sel` is a one-cycle pulse that starts a new command. `bus_rst` is a one-cycle pulse that aborts the current command. A conversion is requested with a pulse on `conv_start`, and the result arrives with a pulse on `conv_done`.

Top module: `thermo_fc_ctrl`

## Requirements
- R1: After reset `alarm`, `tx_valid` and `conv_start` are low and `rx_ready` is high. The scratchpad holds temperature 00AAh, residue count 0Ch, and the limit bytes TH_INIT/TL_INIT, which are also the nonvolatile contents.
- R2: Function code BEh streams 72 bits, each byte least significant bit first, in this byte order:
  - 0: temperature low byte
  - 1: temperature high byte
  - 2: upper limit
  - 3: lower limit
  - 4 and 5: FFh
  - 6: residue count
  - 7: 10h
  - 8: check byte

  After the 72nd bit `tx_valid` falls.
- R3: The check byte is a CRC over bytes 0–7 with polynomial x^8+x^5+x^4+1. The register starts at zero and takes bits least significant first. The check byte always matches the current contents of bytes 0–7.
- R4: Function code 4Eh takes 16 bits, least significant first. The first byte becomes the upper limit and the second the lower limit. Both are written together when the 16th bit is accepted. A `bus_rst` before that leaves both limits unchanged.
- R5: `bus_rst` returns the block to idle from any state except conversion and copy. A scratchpad stream cut short this way starts again at bit 0 of byte 0 on the next BEh.
- R6: Function code 44h raises `conv_start` for exactly one cycle. `rx_ready` then stays low until `conv_done`. At `conv_done` the 16-bit `conv_temp` is latched into bytes 0–1 and `conv_remain` into byte 6.
- R7: At each `conv_done` the flag is recomputed:
  - `alarm` is set when the signed value of temperature bits 8:1 is greater than the signed upper limit, or less than the signed lower limit.
  - Equality raises no alarm.
  - `alarm` changes at no other time.
- R8: Function code 48h holds `rx_ready` low for at least COPY_CYCLES cycles. Afterwards the nonvolatile bank holds the scratchpad limits.
- R9: Function code B8h holds `tx_valid` high. `tx_data` reads 0 while the recall runs and 1 once it is done. At that point the scratchpad limits equal the nonvolatile bank.
- R10: `tx_valid` and `rx_ready` are never high together. While `tx_valid` is high and the bit is not consumed, a 1 on `tx_data` stays 1.
- R11: An unrecognised function code returns the block to idle with `tx_valid` low. The scratchpad is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| sel | input | 1 | Pulse: device selected, a function code follows |
| bus_rst | input | 1 | Pulse: bus reset seen, abort current command |
| rx_valid | input | 1 | Master bit available |
| rx_data | input | 1 | Master bit value |
| rx_ready | output | 1 | Block can accept a master bit |
| tx_valid | output | 1 | Block has a bit for the next read slot |
| tx_data | output | 1 | Bit value for the read slot |
| tx_ready | input | 1 | Read slot taken; bit consumed |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Conversion result valid this cycle |
| conv_temp | input | 16 | Signed temperature, 0.5 degree steps |
| conv_remain | input | 8 | Residue count from the converter |
| alarm | output | 1 | Alarm flag from the last conversion |

## Verification
The bench goes after the alarm comparison at its edges: a reading equal to a limit, a half-degree step above a limit, and negative readings against a negative lower limit. A comparator that used all nine bits, compared unsigned, or used >= would flag these cases wrongly. It cuts a limit write off after one byte and again in the middle of the second byte. A design that commits per byte would leave a corrupted limit behind. It also truncates a scratchpad read, then checks that the recall status starts at 0 and turns to 1, and that copied limits survive an overwrite and come back on recall. A block that kept its bit position, or reported recall done too early, would fail those reads.

// File: rtl/thermo_fc_pkg.sv
package thermo_fc_pkg;
  localparam int TEMP_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int SP_BYTES = 9;
  localparam int SP_BITS  = SP_BYTES * BYTE_W;
  localparam int CRC_BITS = (SP_BYTES - 1) * BYTE_W;

  localparam logic [7:0] OP_CONVERT = 8'h44;
  localparam logic [7:0] OP_WRITE   = 8'h4E;
  localparam logic [7:0] OP_READ    = 8'hBE;
  localparam logic [7:0] OP_COPY    = 8'h48;
  localparam logic [7:0] OP_RECALL  = 8'hB8;

  localparam logic [7:0] PAD_BYTE   = 8'hFF;
  localparam logic [7:0] PER_DEGREE = 8'h10;
  localparam logic [15:0] TEMP_RST  = 16'h00AA;
  localparam logic [7:0] REMAIN_RST = 8'h0C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WRITE, ST_READ, ST_CONV, ST_COPY, ST_RECALL
  } fc_state_e;
endpackage

// File: rtl/thermo_crc8.sv
module thermo_crc8 #(
  parameter int DATA_BITS = 64
) (
  input  logic [DATA_BITS-1:0] data,
  output logic [7:0]           crc
);
  localparam logic [7:0] POLY_REFL = 8'h8C;

  always_comb begin
    logic [7:0] acc;
    logic       fb;
    acc = '0;
    for (int i = 0; i < DATA_BITS; i++) begin
      fb  = acc[0] ^ data[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ POLY_REFL;
    end
    crc = acc;
  end
endmodule

// File: rtl/thermo_nvbank.sv
module thermo_nvbank #(
  parameter int         COPY_CYCLES   = 500000,
  parameter int         RECALL_CYCLES = 8,
  parameter logic [7:0] TH_INIT       = 8'h19,
  parameter logic [7:0] TL_INIT       = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       copy_go,
  input  logic       recall_go,
  input  logic [7:0] th_in,
  input  logic [7:0] tl_in,
  output logic       busy,
  output logic       recall_fin,
  output logic [7:0] th_q,
  output logic [7:0] tl_q
);
  localparam int MAXC = (COPY_CYCLES > RECALL_CYCLES) ? COPY_CYCLES : RECALL_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          op_copy;
  logic [7:0]    th_pend, tl_pend;

  assign recall_fin = busy && (cnt == '0) && !op_copy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_copy <= 1'b0;
      cnt     <= '0;
      th_pend <= '0;
      tl_pend <= '0;
      th_q    <= TH_INIT;
      tl_q    <= TL_INIT;
    end else if (copy_go) begin
      busy    <= 1'b1;
      op_copy <= 1'b1;
      cnt     <= CW'(COPY_CYCLES - 1);
      th_pend <= th_in;
      tl_pend <= tl_in;
    end else if (recall_go) begin
      busy    <= 1'b1;
      op_copy <= 1'b0;
      cnt     <= CW'(RECALL_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        if (op_copy) begin
          th_q <= th_pend;
          tl_q <= tl_pend;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/thermo_alarm_cmp.sv
module thermo_alarm_cmp #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] temp,
  input  logic [7:0]    hi_lim,
  input  logic [7:0]    lo_lim,
  output logic          hit
);
  logic signed [7:0] whole;
  assign whole = $signed(temp[8:1]);
  assign hit   = (whole > $signed(hi_lim)) || (whole < $signed(lo_lim));
endmodule

// File: rtl/thermo_fc_ctrl.sv
module thermo_fc_ctrl
  import thermo_fc_pkg::*;
#(
  parameter int         COPY_CYCLES   = 500000,
  parameter int         RECALL_CYCLES = 8,
  parameter logic [7:0] TH_INIT       = 8'h19,
  parameter logic [7:0] TL_INIT       = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        bus_rst,
  input  logic        rx_valid,
  input  logic        rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic        tx_data,
  input  logic        tx_ready,
  output logic        conv_start,
  input  logic        conv_done,
  input  logic [15:0] conv_temp,
  input  logic [7:0]  conv_remain,
  output logic        alarm
);
  localparam int BCW = $clog2(SP_BITS);
  localparam int WR_BITS = 2 * BYTE_W;

  fc_state_e          state;
  logic [BCW-1:0]     bitcnt;
  logic [7:0]         cmd_sh;
  logic [WR_BITS-1:0] wr_sh;
  logic [TEMP_W-1:0]  sp_temp;
  logic [7:0]         sp_remain, sp_th, sp_tl;
  logic               alarm_q, conv_start_q;

  logic [SP_BITS-1:0] sp_img;
  logic [7:0]         sp_crc;
  logic [7:0]         cmd_next;
  logic [WR_BITS-1:0] wr_next;
  logic               rx_fire, tx_fire, busy_state, take_ctrl;
  logic               cmd_done, copy_go, recall_go;
  logic               nv_busy, recall_fin, new_hit;
  logic [7:0]         nv_th, nv_tl;

  assign busy_state = (state == ST_CONV) || (state == ST_COPY);
  assign take_ctrl  = !busy_state && (bus_rst || sel);
  assign rx_ready   = (state == ST_IDLE) || (state == ST_CMD) || (state == ST_WRITE);
  assign tx_valid   = (state == ST_READ) || (state == ST_RECALL);
  assign rx_fire    = rx_valid && rx_ready;
  assign tx_fire    = tx_valid && tx_ready;
  assign tx_data    = (state == ST_READ) ? sp_img[bitcnt] : !nv_busy;
  assign conv_start = conv_start_q;
  assign alarm      = alarm_q;

  assign cmd_next  = {rx_data, cmd_sh[7:1]};
  assign wr_next   = {rx_data, wr_sh[WR_BITS-1:1]};
  assign cmd_done  = (state == ST_CMD) && rx_fire && !take_ctrl && (bitcnt == BCW'(BYTE_W - 1));
  assign copy_go   = cmd_done && (cmd_next == OP_COPY);
  assign recall_go = cmd_done && (cmd_next == OP_RECALL);

  assign sp_img = {sp_crc, PER_DEGREE, sp_remain, PAD_BYTE, PAD_BYTE, sp_tl, sp_th, sp_temp};

  thermo_crc8 #(.DATA_BITS(CRC_BITS)) u_crc (
    .data (sp_img[CRC_BITS-1:0]),
    .crc  (sp_crc)
  );

  thermo_alarm_cmp #(.TW(TEMP_W)) u_cmp (
    .temp   (conv_temp),
    .hi_lim (sp_th),
    .lo_lim (sp_tl),
    .hit    (new_hit)
  );

  thermo_nvbank #(
    .COPY_CYCLES   (COPY_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES),
    .TH_INIT       (TH_INIT),
    .TL_INIT       (TL_INIT)
  ) u_nv (
    .clk        (clk),
    .rst_n      (rst_n),
    .copy_go    (copy_go),
    .recall_go  (recall_go),
    .th_in      (sp_th),
    .tl_in      (sp_tl),
    .busy       (nv_busy),
    .recall_fin (recall_fin),
    .th_q       (nv_th),
    .tl_q       (nv_tl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bitcnt       <= '0;
      cmd_sh       <= '0;
      wr_sh        <= '0;
      sp_temp      <= TEMP_RST;
      sp_remain    <= REMAIN_RST;
      sp_th        <= TH_INIT;
      sp_tl        <= TL_INIT;
      alarm_q      <= 1'b0;
      conv_start_q <= 1'b0;
    end else begin
      conv_start_q <= 1'b0;
      if (recall_fin) begin
        sp_th <= nv_th;
        sp_tl <= nv_tl;
      end
      if (take_ctrl) begin
        state  <= bus_rst ? ST_IDLE : ST_CMD;
        bitcnt <= '0;
      end else begin
        unique case (state)
          ST_CMD: if (rx_fire) begin
            cmd_sh <= cmd_next;
            bitcnt <= bitcnt + 1'b1;
            if (cmd_done) begin
              bitcnt <= '0;
              unique case (cmd_next)
                OP_CONVERT: begin
                  state        <= ST_CONV;
                  conv_start_q <= 1'b1;
                end
                OP_WRITE:  state <= ST_WRITE;
                OP_READ:   state <= ST_READ;
                OP_COPY:   state <= ST_COPY;
                OP_RECALL: state <= ST_RECALL;
                default:   state <= ST_IDLE;
              endcase
            end
          end
          ST_WRITE: if (rx_fire) begin
            wr_sh  <= wr_next;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == BCW'(WR_BITS - 1)) begin
              sp_th <= wr_next[7:0];
              sp_tl <= wr_next[15:8];
              state <= ST_IDLE;
            end
          end
          ST_READ: if (tx_fire) begin
            if (bitcnt == BCW'(SP_BITS - 1)) state <= ST_IDLE;
            else bitcnt <= bitcnt + 1'b1;
          end
          ST_CONV: if (conv_done) begin
            sp_temp   <= conv_temp;
            sp_remain <= conv_remain;
            alarm_q   <= new_hit;
            state     <= ST_IDLE;
          end
          ST_COPY: if (!nv_busy) state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/thermo_fc_chk.sv
module thermo_fc_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic bus_rst,
  input logic rx_ready,
  input logic tx_valid,
  input logic tx_data,
  input logic tx_ready,
  input logic conv_start,
  input logic conv_done,
  input logic alarm
);
  AST_CONV_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R6
  AST_CONV_HOLDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !rx_ready); // R6
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready)); // R10
  AST_TX_ONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_data && !tx_ready && !bus_rst && !sel) |=> (tx_valid && tx_data)); // R10
  AST_ALARM_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm != $past(alarm)) |-> $past(conv_done)); // R7
endmodule

bind thermo_fc_ctrl thermo_fc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .bus_rst    (bus_rst),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .alarm      (alarm)
);

// File: tb/tb_thermo_fc_ctrl.sv
module tb_thermo_fc_ctrl;
  localparam int COPY_N   = 40;
  localparam int RECALL_N = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, bus_rst = 1'b0, rx_valid = 1'b0, rx_data = 1'b0, tx_ready = 1'b0;
  logic conv_done = 1'b0;
  logic [15:0] conv_temp = '0;
  logic [7:0]  conv_remain = '0;
  logic rx_ready, tx_valid, tx_data, conv_start, alarm;

  int checks = 0, fails = 0;
  bit started = 0, finished = 0;

  // reference model
  logic [15:0] m_temp = 16'h00AA;
  logic [7:0]  m_remain = 8'h0C, m_th = 8'h19, m_tl = 8'h05;
  logic [7:0]  m_nvth = 8'h19, m_nvtl = 8'h05;
  bit          m_alarm = 0;

  always #10 clk = ~clk;

  thermo_fc_ctrl #(.COPY_CYCLES(COPY_N), .RECALL_CYCLES(RECALL_N),
                   .TH_INIT(8'h19), .TL_INIT(8'h05)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .bus_rst(bus_rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .conv_start(conv_start), .conv_done(conv_done), .conv_temp(conv_temp),
    .conv_remain(conv_remain), .alarm(alarm));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_byte(input int i);
    case (i)
      0: return m_temp[7:0];
      1: return m_temp[15:8];
      2: return m_th;
      3: return m_tl;
      4, 5: return 8'hFF;
      6: return m_remain;
      7: return 8'h10;
      default: begin
        logic [7:0] c = 8'h00;
        for (int b = 0; b < 8; b++) begin
          logic [7:0] d = ref_byte(b);
          for (int k = 0; k < 8; k++) begin
            bit mix = c[0] ^ d[k];
            c = {1'b0, c[7:1]};
            if (mix) c = c ^ 8'h8C;
          end
        end
        return c;
      end
    endcase
  endfunction

  function automatic bit ref_alarm(input logic [15:0] t);
    int deg = $signed(t) >>> 1;
    return (deg > int'($signed(m_th))) || (deg < int'($signed(m_tl)));
  endfunction

  // per-clock comparison of the alarm flag against the model (R7)
  always begin
    @(posedge clk); #5;
    if (started && !finished) check("R7", alarm, m_alarm);
  end

  task automatic pulse_sel();
    sel = 1'b1; @(negedge clk); sel = 1'b0;
  endtask
  task automatic pulse_rst();
    bus_rst = 1'b1; @(negedge clk); bus_rst = 1'b0;
  endtask
  task automatic put_bit(input bit b);
    rx_valid = 1'b1; rx_data = b; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask
  task automatic get_bit(output bit v, output bit b);
    tx_ready = 1'b1; v = tx_valid; b = tx_data; @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic command(input logic [7:0] op);
    pulse_rst(); pulse_sel(); put_byte(op);
  endtask

  task automatic read_all(input string req);
    bit v, b;
    logic [7:0] got;
    command(8'hBE);
    for (int i = 0; i < 9; i++) begin
      got = '0;
      for (int k = 0; k < 8; k++) begin
        get_bit(v, b);
        got[k] = b;
        if (!v) check(req, 0, 1);
      end
      check(req, got, ref_byte(i));
    end
    check("R2", tx_valid, 0);
  endtask

  task automatic write_lim(input logic [7:0] th, input logic [7:0] tl);
    command(8'h4E); put_byte(th); put_byte(tl);
    m_th = th; m_tl = tl;
  endtask

  task automatic convert(input logic [15:0] t, input logic [7:0] rem);
    command(8'h44);
    check("R6", conv_start, 1);
    check("R6", rx_ready, 0);
    @(negedge clk); @(negedge clk);
    check("R6", conv_start, 0);
    check("R6", rx_ready, 0);
    conv_done = 1'b1; conv_temp = t; conv_remain = rem;
    @(posedge clk); #1;
    m_alarm = ref_alarm(t); m_temp = t; m_remain = rem;
    @(negedge clk); conv_done = 1'b0;
    check("R6", rx_ready, 1);
  endtask

  initial begin : watchdog
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit v, b;
    int lo, zeros;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    // R1 reset state
    check("R1", alarm, 0);
    check("R1", tx_valid, 0);
    check("R1", conv_start, 0);
    check("R1", rx_ready, 1);
    read_all("R1");
    // R4 full write, R2/R3 readback
    write_lim(8'h1E, 8'hF6);
    read_all("R3");
    // R6/R7 conversions including boundaries
    convert(16'h0032, 8'h07); check("R7", alarm, 0);
    read_all("R3");
    convert(16'h003E, 8'h02); check("R7", alarm, 1);
    convert(16'h003D, 8'h09); check("R7", alarm, 0);
    convert(16'hFFCE, 8'h0B); check("R7", alarm, 1);
    convert(16'hFFEC, 8'h04); check("R7", alarm, 0);
    read_all("R6");
    // R4 interrupted writes
    command(8'h4E); put_byte(8'h55); pulse_rst();
    read_all("R4");
    command(8'h4E); put_byte(8'h66); for (int i = 0; i < 4; i++) put_bit(1'b1);
    pulse_rst();
    read_all("R4");
    // R5 truncated read then restart
    command(8'hBE);
    for (int i = 0; i < 13; i++) get_bit(v, b);
    pulse_rst();
    read_all("R5");
    // R11 unknown code
    command(8'hAA);
    check("R11", tx_valid, 0);
    check("R11", rx_ready, 1);
    read_all("R11");
    // R8 copy
    write_lim(8'h40, 8'h01);
    command(8'h48);
    lo = 0;
    while (!rx_ready && lo < 10000) begin lo++; @(negedge clk); end
    check("R8", lo >= COPY_N, 1);
    m_nvth = 8'h40; m_nvtl = 8'h01;
    write_lim(8'h11, 8'h22);
    read_all("R4");
    // R9 recall
    command(8'hB8);
    get_bit(v, b);
    check("R9", v, 1);
    check("R9", b, 0);
    zeros = 1;
    while (b == 0 && zeros < 100) begin get_bit(v, b); if (b == 0) zeros++; end
    check("R9", b, 1);
    check("R9", zeros <= RECALL_N + 1, 1);
    get_bit(v, b);
    check("R9", b, 1);
    m_th = m_nvth; m_tl = m_nvtl;
    read_all("R9");
    // R7: limits changed, flag stays until next conversion
    write_lim(8'h00, 8'h00);
    convert(16'h0004, 8'h01); check("R7", alarm, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule